// File: doc/BRIEF.md
# Single-Level Interrupt Controller

This block sits beside the decode stage of a small RISC core that cannot service one exception inside another. It owns the single global interrupt-enable bit. It decides at each instruction boundary whether the external request line is taken. When it takes the request, it redirects the fetch address, acknowledges the request and saves the return address.

The return address is written through a register-file write port into general register 31. That register doubles as the saved-PC register. The core's decoder tells the block when the current instruction is an enable, disable or return-from-interrupt operation. It also flags when the current instruction sits in a branch delay slot.

An accepted request is taken in front of the instruction at the boundary. The current PC is saved and that instruction runs again after the return. The instruction's own effect on the enable bit or on the fetch address is dropped.

Top module: `irq_ctl`

## Requirements
- R1: After reset the enable bit is 0, so a high request produces no acknowledge, no PC override and no register write.
- R2: A decoded enable operation sets the enable bit from the next cycle. A request present then is acknowledged in the same cycle it is seen.
- R3: A decoded disable operation clears the enable bit, so a request in the following cycle is not acknowledged.
- R4: In the cycle a request is accepted, the block asserts `irq_ack` and `pc_load`, drives `pc_target` to the vector parameter, and asserts `rf_we` with `rf_waddr` equal to 31 and `rf_wdata` equal to `cur_pc`.
- R5: Acceptance clears the enable bit, so `irq_ack` lasts exactly one clock even when the request stays high.
- R6: A return operation asserts `pc_load` with `pc_target` equal to `link_val` (the value read from register 31), and sets the enable bit from the next cycle.
- R7: No request is accepted while `slot_busy` is high. A pending request is accepted in the first cycle `slot_busy` is low.
- R8: When a request is accepted in the same cycle as an enable or return operation, the acceptance wins. The target is the vector and the enable bit is 0 afterwards.
- R9: With no acceptance and no return, `pc_load` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| irq_req | input | 1 | External interrupt request |
| op_enable | input | 1 | Current instruction is the enable operation |
| op_disable | input | 1 | Current instruction is the disable operation |
| op_return | input | 1 | Current instruction is return-from-interrupt |
| slot_busy | input | 1 | Current instruction occupies a branch delay slot |
| cur_pc | input | AW | Address of the instruction at this boundary |
| link_val | input | AW | Current content of register 31 |
| irq_ack | output | 1 | Request accepted this cycle |
| pc_load | output | 1 | Override the fetch address |
| pc_target | output | AW | Address to fetch when `pc_load` is high |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | RIDX_W | Register-file write index (always 31) |
| rf_wdata | output | AW | Register-file write data |

## Verification
Acceptance, its PC override and its register write are combinational on the same cycle as the request and operation inputs. The bench therefore drives inputs just after a falling edge and reads these outputs one nanosecond later, before the next rising edge. Changes to the enable bit from enable, disable, return or acceptance appear only one rising edge later. The bench observes them through `irq_ack` in the following cycle, with the request held high.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int              AW       = 32,
  parameter int              RIDX_W   = 5,
  parameter int              LINK_REG = 31,
  parameter logic [AW-1:0]   VEC_ADDR = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req,
  input  logic              op_enable,
  input  logic              op_disable,
  input  logic              op_return,
  input  logic              slot_busy,
  input  logic [AW-1:0]     cur_pc,
  input  logic [AW-1:0]     link_val,
  output logic              irq_ack,
  output logic              pc_load,
  output logic [AW-1:0]     pc_target,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [AW-1:0]     rf_wdata
);
  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  logic ie;
  logic take;

  assign take = ie & irq_req & ~slot_busy;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                         ie <= 1'b0;
    else if (take)                   ie <= 1'b0;
    else if (op_return | op_enable)  ie <= 1'b1;
    else if (op_disable)             ie <= 1'b0;
  end

  assign irq_ack   = take;
  assign pc_load   = take | op_return;
  assign pc_target = take ? VEC_ADDR : link_val;
  assign rf_we     = take;
  assign rf_waddr  = LINK_IDX;
  assign rf_wdata  = cur_pc;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_ADDR = 32'h0000_0040
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_req,
  input logic          op_return,
  input logic          slot_busy,
  input logic [AW-1:0] link_val,
  input logic          irq_ack,
  input logic          pc_load,
  input logic [AW-1:0] pc_target,
  input logic          rf_we
);
  a_r5_ack_single: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> irq_req);
  a_r7_no_ack_in_slot: assert property (@(posedge clk) disable iff (rst)
    slot_busy |-> !irq_ack);
  a_r4_entry_redirect: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (pc_load && rf_we && pc_target == VEC_ADDR));
  a_r6_return_target: assert property (@(posedge clk) disable iff (rst)
    (op_return && !irq_ack) |-> (pc_load && pc_target == link_val));
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (!irq_ack && !op_return) |-> (!pc_load && !rf_we));
endmodule

bind irq_ctl irq_ctl_chk #(.AW(AW), .VEC_ADDR(VEC_ADDR)) chk_i (
  .clk(clk), .rst(rst), .irq_req(irq_req), .op_return(op_return),
  .slot_busy(slot_busy), .link_val(link_val), .irq_ack(irq_ack),
  .pc_load(pc_load), .pc_target(pc_target), .rf_we(rf_we)
);

// File: tb/irq_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_ctl_tb_top;
  localparam logic [31:0] VEC = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 0, op_enable = 0, op_disable = 0, op_return = 0, slot_busy = 0;
  logic [31:0] cur_pc = 0, link_val = 0;
  logic        irq_ack, pc_load, rf_we;
  logic [31:0] pc_target, rf_wdata;
  logic [4:0]  rf_waddr;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_ctl #(.VEC_ADDR(VEC)) dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .op_enable(op_enable),
    .op_disable(op_disable), .op_return(op_return), .slot_busy(slot_busy),
    .cur_pc(cur_pc), .link_val(link_val), .irq_ack(irq_ack), .pc_load(pc_load),
    .pc_target(pc_target), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    irq_req = 0; op_enable = 0; op_disable = 0; op_return = 0; slot_busy = 0;
  endtask

  task automatic settle(); #1; endtask

  task automatic t_reset();
    next_cycle(); irq_req = 1; settle();
    check("R1 ack", irq_ack, 0);
    check("R1 pc_load", pc_load, 0);
    check("R9 rf_we", rf_we, 0);
  endtask

  task automatic t_enable_accept();
    next_cycle(); op_enable = 1; settle();
    check("R9 pc_load on enable", pc_load, 0);
    next_cycle(); irq_req = 1; cur_pc = 32'h0000_0100; settle();
    check("R2 ack", irq_ack, 1);
    check("R4 pc_load", pc_load, 1);
    check("R4 target", pc_target, VEC);
    check("R4 rf_we", rf_we, 1);
    check("R4 waddr", rf_waddr, 31);
    check("R4 wdata", rf_wdata, 32'h0000_0100);
    next_cycle(); irq_req = 1; settle();
    check("R5 second ack", irq_ack, 0);
    check("R5 rf_we", rf_we, 0);
  endtask

  task automatic t_return();
    next_cycle(); op_return = 1; link_val = 32'h0000_0100; settle();
    check("R6 pc_load", pc_load, 1);
    check("R6 target", pc_target, 32'h0000_0100);
    check("R6 no write", rf_we, 0);
    next_cycle(); irq_req = 1; cur_pc = 32'h0000_0200; settle();
    check("R6 reenabled ack", irq_ack, 1);
    check("R6 wdata", rf_wdata, 32'h0000_0200);
  endtask

  task automatic t_disable();
    next_cycle(); op_enable = 1;
    next_cycle(); op_disable = 1; settle();
    check("R3 ack with disable op, no req", irq_ack, 0);
    next_cycle(); irq_req = 1; settle();
    check("R3 ack after disable", irq_ack, 0);
    check("R3 pc_load", pc_load, 0);
  endtask

  task automatic t_slot();
    next_cycle(); op_enable = 1;
    next_cycle(); irq_req = 1; slot_busy = 1; cur_pc = 32'h0000_0300; settle();
    check("R7 slot cycle 1", irq_ack, 0);
    next_cycle(); irq_req = 1; slot_busy = 1; cur_pc = 32'h0000_0304; settle();
    check("R7 slot cycle 2", irq_ack, 0);
    next_cycle(); irq_req = 1; cur_pc = 32'h0000_0308; settle();
    check("R7 taken after slot", irq_ack, 1);
    check("R7 saved pc", rf_wdata, 32'h0000_0308);
  endtask

  task automatic t_preempt();
    next_cycle(); op_enable = 1;
    next_cycle(); irq_req = 1; op_return = 1; link_val = 32'h0000_0500; settle();
    check("R8 ack over return", irq_ack, 1);
    check("R8 target is vector", pc_target, VEC);
    next_cycle(); irq_req = 1; settle();
    check("R8 ie low after return clash", irq_ack, 0);
    next_cycle(); op_enable = 1;
    next_cycle(); irq_req = 1; op_enable = 1; settle();
    check("R8 ack over enable", irq_ack, 1);
    next_cycle(); irq_req = 1; settle();
    check("R8 ie low after enable clash", irq_ack, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    settle();
    check("R1 ack in reset", irq_ack, 0);
    rst = 0;
    t_reset();
    t_enable_accept();
    t_return();
    t_disable();
    t_slot();
    t_preempt();
    next_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule